// File: doc/BRIEF.md
# Self-Timed Flash Write Engine

This block performs the slow write operations of a serial flash memory model on an internal byte array: page program, sector erase, whole-array erase and status-protection update. A serial front end decodes the command and address and passes them in. It then hands over each completed data byte and reports the end of the chip-select frame, with a flag that says whether the frame ended on a byte boundary. Data bytes for a program are gathered in a one-page buffer. When the frame closes, the engine decides whether to run a cycle.

An accepted cycle raises `busy` for a duration fixed by parameters counted in clocks. During that time the engine walks the array and applies the result. When the time runs out, `busy` and the write-enable latch drop together. While busy, the engine ignores every other input except the read port address. The read port is only meaningful when the engine is idle.

Top module: `flash_write_engine`

## Requirements
- R1: After reset, `busy`, `wel`, `sr_wpen` and `sr_bp` are all 0.
- R2: When idle, a `wel_set` pulse sets `wel` and a `wel_clr` pulse clears it.
- R3: A program (`cmd_kind` 0) with n data bytes at address A changes page byte (A mod 256 + k) mod 256, for k from 0 to n-1, to the bitwise AND of its old value and the k-th data byte. All other bytes keep their values.
- R4: With more than 256 data bytes, the offset keeps wrapping inside the page, and each later byte replaces the earlier byte sent to the same offset.
- R5: A cycle starts only on `frame_end` with `frame_aligned` high. A frame that ends unaligned discards the command, starts nothing and leaves `wel` unchanged.
- R6: If `wel` is 0 at the end of the frame, the command is ignored and the array is unchanged.
- R7: `busy` rises on the clock after an accepted `frame_end` and stays high for exactly the cycle length. A program lasts min(n,256)*T_BYTE clocks, a sector erase T_SECT, a chip erase T_CHIP and a status write T_SR.
- R8: `busy` and `wel` fall on the same clock edge when the cycle ends.
- R9: A sector erase (`cmd_kind` 1) at any address sets every byte of the 2^SECT_W-byte sector holding that address to 0xFF and leaves other sectors alone.
- R10: `sr_bp` value 1 locks the top quarter of the sectors, 2 locks the top half and 3 locks all of them. A program or sector erase aimed at a locked sector is ignored, with no cycle and `wel` kept. A chip erase (`cmd_kind` 2) erases only unlocked sectors.
- R11: A status write (`cmd_kind` 3) takes bit 7 of its first data byte into `sr_wpen` and bits 3:2 into `sr_bp`, both applied when the cycle ends. When `sr_wpen` is 1 and `prot_n` is low, the write is refused with no cycle.
- R12: While `busy` is high, `cmd_start`, `byte_valid`, `frame_end`, `wel_set` and `wel_clr` have no effect.
- R13: When idle, `rd_data` shows the array byte at `rd_addr` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Pulse: new command decoded |
| cmd_kind | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 status write |
| cmd_addr | input | ADDR_W | Command byte address |
| byte_valid | input | 1 | Pulse: one data byte complete |
| byte_data | input | 8 | Data byte |
| frame_end | input | 1 | Pulse: chip select released |
| frame_aligned | input | 1 | Frame ended on a byte boundary |
| wel_set | input | 1 | Write-enable command |
| wel_clr | input | 1 | Write-disable command |
| prot_n | input | 1 | Hardware protect pin, active low |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array read data, one clock latency |
| busy | output | 1 | Write cycle in progress |
| wel | output | 1 | Write-enable latch |
| sr_bp | output | 2 | Sector lock level |
| sr_wpen | output | 1 | Hardware protect enable |

## Verification
Page programs are applied with short runs that cross the page end, runs of exactly one byte, and runs of more than 256 bytes. The short runs show whether the offset wraps inside the page rather than spilling into the next page. The long runs separate "latest byte wins" from "first byte wins". Programming the same bytes twice without an erase shows whether the array stores old AND new or simply overwrites. Further random programs at random offsets and lengths, mixed with random sector erases, are compared against a bench model of the whole page. The measured busy length on each run tells apart a count taken per byte from a count taken once per page.

// File: rtl/fwe_pkg.sv
package fwe_pkg;

  typedef enum logic [1:0] {
    K_PROG   = 2'd0,
    K_SERASE = 2'd1,
    K_CERASE = 2'd2,
    K_SRWR   = 2'd3
  } op_kind_t;

  typedef enum logic [1:0] {
    W_IDLE,
    W_PROG_RD,
    W_PROG_WR,
    W_ERASE
  } walk_st_t;

  // lock level 1: top quarter, 2: top half, 3: every sector
  function automatic logic sect_locked(input logic [1:0] lvl,
                                       input int unsigned sect,
                                       input int unsigned nsect);
    logic r;
    case (lvl)
      2'd0:    r = 1'b0;
      2'd1:    r = (sect >= nsect - nsect / 4);
      2'd2:    r = (sect >= nsect / 2);
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fwe_ram.sv
module fwe_ram #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fwe_cycle_timer.sv
module fwe_cycle_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= len - CNT_W'(1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CNT_W'(1);
    end
  end

  assign last = busy && (cnt == '0);

  // R7: a started cycle must have a nonzero length
  a_r7_len_positive: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |-> (len != '0));

  // R7: busy cannot drop before the count reaches zero
  a_r7_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != '0) |=> busy);
endmodule

// File: rtl/flash_write_engine.sv
module flash_write_engine
  import fwe_pkg::*;
#(
  parameter int NUM_SECT = 4,
  parameter int SECT_W   = 9,
  parameter int PAGE_W   = 8,
  parameter int T_BYTE   = 4,
  parameter int T_SECT   = 600,
  parameter int T_CHIP   = 2100,
  parameter int T_SR     = 20,
  localparam int ADDR_W  = $clog2(NUM_SECT) + SECT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              frame_end,
  input  logic              frame_aligned,
  input  logic              wel_set,
  input  logic              wel_clr,
  input  logic              prot_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              wel,
  output logic [1:0]        sr_bp,
  output logic              sr_wpen
);
  localparam int SIDX_W     = $clog2(NUM_SECT);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int SECT_BYTES = 1 << SECT_W;
  localparam int MEM_BYTES  = NUM_SECT * SECT_BYTES;
  localparam int CNT_W      = 32;
  localparam logic [PAGE_W:0] PCNT_FULL = (PAGE_W+1)'(PAGE_BYTES);

  // ---------------- command collection ----------------
  logic              pend;
  op_kind_t          pkind;
  logic [ADDR_W-1:0] paddr;
  logic [PAGE_W-1:0] pptr;
  logic [PAGE_W:0]   pcnt;
  logic [1:0]        new_bp;
  logic              new_wpen;

  logic take_byte, buf_we;
  assign take_byte = !busy && !frame_end && !cmd_start && byte_valid && pend &&
                     (pkind == K_PROG || pkind == K_SRWR);
  assign buf_we    = take_byte && (pkind == K_PROG);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      pkind    <= K_PROG;
      paddr    <= '0;
      pptr     <= '0;
      pcnt     <= '0;
      new_bp   <= '0;
      new_wpen <= 1'b0;
    end else if (!busy) begin
      if (frame_end) begin
        pend <= 1'b0;
      end else if (cmd_start) begin
        pend  <= 1'b1;
        pkind <= op_kind_t'(cmd_kind);
        paddr <= cmd_addr;
        pptr  <= cmd_addr[PAGE_W-1:0];
        pcnt  <= '0;
      end else if (take_byte) begin
        if (pcnt == '0) begin
          new_bp   <= byte_data[3:2];
          new_wpen <= byte_data[7];
        end
        pptr <= pptr + PAGE_W'(1);
        if (pcnt != PCNT_FULL) pcnt <= pcnt + (PAGE_W+1)'(1);
      end
    end
  end

  // ---------------- accept decision ----------------
  logic [SIDX_W-1:0] tgt_sect;
  logic              tgt_locked, sr_blocked, kind_ok, go;
  logic [CNT_W-1:0]  cyc_len;

  assign tgt_sect   = paddr[ADDR_W-1:SECT_W];
  assign tgt_locked = sect_locked(sr_bp, int'(tgt_sect), NUM_SECT);
  assign sr_blocked = sr_wpen && !prot_n;

  always_comb begin
    case (pkind)
      K_PROG: begin
        kind_ok = (pcnt != '0) && !tgt_locked;
        cyc_len = CNT_W'(pcnt) * CNT_W'(T_BYTE);
      end
      K_SERASE: begin
        kind_ok = !tgt_locked;
        cyc_len = CNT_W'(T_SECT);
      end
      K_CERASE: begin
        kind_ok = 1'b1;
        cyc_len = CNT_W'(T_CHIP);
      end
      default: begin
        kind_ok = (pcnt != '0) && !sr_blocked;
        cyc_len = CNT_W'(T_SR);
      end
    endcase
  end

  assign go = frame_end && frame_aligned && !busy && pend && wel && kind_ok;

  // ---------------- cycle timer ----------------
  logic tmr_last;

  fwe_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (go),
    .len   (cyc_len),
    .busy  (busy),
    .last  (tmr_last)
  );

  // ---------------- latch and status ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      wel     <= 1'b0;
      sr_bp   <= '0;
      sr_wpen <= 1'b0;
    end else if (tmr_last) begin
      wel <= 1'b0;
      if (pkind == K_SRWR) begin
        sr_bp   <= new_bp;
        sr_wpen <= new_wpen;
      end
    end else if (!busy) begin
      if (wel_set)      wel <= 1'b1;
      else if (wel_clr) wel <= 1'b0;
    end
  end

  // ---------------- array walker ----------------
  walk_st_t          wst;
  logic [ADDR_W-1:0] wptr;
  logic [ADDR_W:0]   wrem;
  logic              wchip;

  always_ff @(posedge clk) begin
    if (rst) begin
      wst   <= W_IDLE;
      wptr  <= '0;
      wrem  <= '0;
      wchip <= 1'b0;
    end else begin
      case (wst)
        W_IDLE: if (go) begin
          case (pkind)
            K_PROG: begin
              wst  <= W_PROG_RD;
              wptr <= paddr;
              wrem <= (ADDR_W+1)'(pcnt);
            end
            K_SERASE: begin
              wst   <= W_ERASE;
              wptr  <= {tgt_sect, {SECT_W{1'b0}}};
              wrem  <= (ADDR_W+1)'(SECT_BYTES);
              wchip <= 1'b0;
            end
            K_CERASE: begin
              wst   <= W_ERASE;
              wptr  <= '0;
              wrem  <= (ADDR_W+1)'(MEM_BYTES);
              wchip <= 1'b1;
            end
            default: wst <= W_IDLE;
          endcase
        end
        W_PROG_RD: wst <= W_PROG_WR;
        W_PROG_WR: begin
          wptr <= {wptr[ADDR_W-1:PAGE_W], wptr[PAGE_W-1:0] + PAGE_W'(1)};
          wrem <= wrem - (ADDR_W+1)'(1);
          wst  <= (wrem == (ADDR_W+1)'(1)) ? W_IDLE : W_PROG_RD;
        end
        default: begin
          wptr <= wptr + ADDR_W'(1);
          wrem <= wrem - (ADDR_W+1)'(1);
          if (wrem == (ADDR_W+1)'(1)) wst <= W_IDLE;
        end
      endcase
    end
  end

  // ---------------- storage ----------------
  logic [7:0]        buf_q, arr_q, arr_wdata;
  logic [ADDR_W-1:0] arr_raddr;
  logic              arr_we, walk_skip;

  assign walk_skip = wchip && sect_locked(sr_bp, int'(wptr[ADDR_W-1:SECT_W]), NUM_SECT);
  assign arr_raddr = (wst == W_PROG_RD) ? wptr : rd_addr;
  assign arr_we    = (wst == W_PROG_WR) || ((wst == W_ERASE) && !walk_skip);
  assign arr_wdata = (wst == W_PROG_WR) ? (arr_q & buf_q) : 8'hFF;

  fwe_ram #(.DW(8), .AW(PAGE_W)) u_page_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (pptr),
    .wdata (byte_data),
    .raddr (wptr[PAGE_W-1:0]),
    .rdata (buf_q)
  );

  fwe_ram #(.DW(8), .AW(ADDR_W)) u_array (
    .clk   (clk),
    .we    (arr_we),
    .waddr (wptr),
    .wdata (arr_wdata),
    .raddr (arr_raddr),
    .rdata (arr_q)
  );

  assign rd_data = arr_q;

  // ---------------- assertions ----------------
  // R8: the latch stays set for the whole cycle
  a_r8_wel_held: assert property (@(posedge clk) disable iff (rst)
    busy |-> wel);

  // R8: latch is clear once busy has dropped
  a_r8_end_clears_wel: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel);

  // R5: a cycle only begins after an aligned frame end
  a_r5_start_on_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(frame_end && frame_aligned));

  // R7: the array walk is finished before busy drops
  a_r7_walk_before_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (wst == W_IDLE));

  // R11: status bits change only at the end of a cycle
  a_r11_status_stable: assert property (@(posedge clk) disable iff (rst)
    (busy && !tmr_last) |=> ($stable(sr_bp) && $stable(sr_wpen)));
endmodule

// File: tb/flash_write_engine_tb.sv
`timescale 1ns/1ps
module flash_write_engine_tb;
  localparam int NUM_SECT = 4;
  localparam int SECT_W   = 9;
  localparam int PAGE_W   = 8;
  localparam int T_BYTE   = 4;
  localparam int T_SECT   = 600;
  localparam int T_CHIP   = 2100;
  localparam int T_SR     = 20;
  localparam int ADDR_W   = 11;
  localparam int SECT_B   = 1 << SECT_W;
  localparam int MEM_B    = NUM_SECT * SECT_B;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst = 1'b1;
  logic              cmd_start = 0, byte_valid = 0, frame_end = 0, frame_aligned = 0;
  logic              wel_set = 0, wel_clr = 0, prot_n = 1;
  logic [1:0]        cmd_kind = 0;
  logic [ADDR_W-1:0] cmd_addr = 0, rd_addr = 0;
  logic [7:0]        byte_data = 0, rd_data;
  logic              busy, wel, sr_wpen;
  logic [1:0]        sr_bp;

  flash_write_engine #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W), .PAGE_W(PAGE_W),
    .T_BYTE(T_BYTE), .T_SECT(T_SECT), .T_CHIP(T_CHIP), .T_SR(T_SR)) u_dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .frame_end(frame_end),
    .frame_aligned(frame_aligned), .wel_set(wel_set), .wel_clr(wel_clr), .prot_n(prot_n),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .wel(wel), .sr_bp(sr_bp),
    .sr_wpen(sr_wpen));

  int n_chk = 0, n_bad = 0;
  logic [7:0] model [MEM_B];
  logic [1:0] m_bp = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit locked(input logic [1:0] lvl, input int sect);
    case (lvl)
      2'd0: return 1'b0;
      2'd1: return sect >= NUM_SECT - NUM_SECT / 4;
      2'd2: return sect >= NUM_SECT / 2;
      default: return 1'b1;
    endcase
  endfunction

  task automatic pulse_wel(input bit set);
    @(negedge clk); wel_set = set; wel_clr = !set;
    @(negedge clk); wel_set = 0; wel_clr = 0;
  endtask

  task automatic start_cmd(input int kind, input int addr);
    @(negedge clk); cmd_start = 1; cmd_kind = 2'(kind); cmd_addr = ADDR_W'(addr);
    @(negedge clk); cmd_start = 0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk); byte_valid = 1; byte_data = d;
    @(negedge clk); byte_valid = 0;
  endtask

  task automatic end_frame(input bit aligned);
    @(negedge clk); frame_end = 1; frame_aligned = aligned;
    @(negedge clk); frame_end = 0; frame_aligned = 0;
  endtask

  // called at the first negedge after the frame end; returns busy length in clocks
  task automatic busy_len(output int len);
    realtime t0;
    t0 = $realtime;
    while (busy && ($realtime - t0) < 100000.0) @(negedge clk);
    len = int'(($realtime - t0) / 10.0);
  endtask

  task automatic read_byte(input int a, output logic [7:0] d);
    @(negedge clk); rd_addr = ADDR_W'(a);
    @(negedge clk); d = rd_data;
  endtask

  task automatic check_region(input int base, input int n, input string req);
    int bad = 0;
    logic [7:0] fa = 0, fe = 0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      read_byte(base + i, d);
      if (d !== model[base + i]) begin
        if (bad == 0) begin fa = d; fe = model[base + i]; end
        bad++;
      end
    end
    chk(bad == 0, req, fa, fe);
  endtask

  task automatic do_program(input int addr, input int n, input bit aligned,
                            input bit exp_go, input string req);
    logic [7:0] pb [256];
    int len, cnt, pbase, st;
    bit wel0;
    wel0 = wel;
    pbase = addr & ~255;
    st = addr & 255;
    start_cmd(0, addr);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = 8'($urandom);
      pb[(st + k) % 256] = d;
      send_byte(d);
    end
    end_frame(aligned);
    busy_len(len);
    cnt = (n > 256) ? 256 : n;
    chk(len == (exp_go ? cnt * T_BYTE : 0), {req, "/R7 program busy length"}, len,
        exp_go ? cnt * T_BYTE : 0);
    chk(wel == (exp_go ? 1'b0 : wel0), {req, "/R8 latch after program"}, wel,
        exp_go ? 0 : wel0);
    if (exp_go)
      for (int j = 0; j < cnt; j++)
        model[pbase + (st + j) % 256] = model[pbase + (st + j) % 256] & pb[(st + j) % 256];
  endtask

  task automatic do_erase(input int kind, input int addr, input bit exp_go, input string req);
    int len, exp;
    start_cmd(kind, addr);
    end_frame(1);
    busy_len(len);
    exp = !exp_go ? 0 : (kind == 1 ? T_SECT : T_CHIP);
    chk(len == exp, {req, "/R7 erase busy length"}, len, exp);
    if (exp_go) begin
      for (int a = 0; a < MEM_B; a++) begin
        if (kind == 1 && (a >> SECT_W) == (addr >> SECT_W)) model[a] = 8'hFF;
        if (kind == 2 && !locked(m_bp, a >> SECT_W)) model[a] = 8'hFF;
      end
    end
  endtask

  task automatic do_status(input logic [7:0] d, input bit exp_go, input string req);
    int len;
    logic [1:0] bp0;
    logic wp0;
    bp0 = sr_bp; wp0 = sr_wpen;
    start_cmd(3, 0);
    send_byte(d);
    end_frame(1);
    busy_len(len);
    chk(len == (exp_go ? T_SR : 0), {req, "/R7 status busy length"}, len, exp_go ? T_SR : 0);
    chk(sr_bp == (exp_go ? d[3:2] : bp0), {req, " lock level"}, sr_bp, exp_go ? d[3:2] : bp0);
    chk(sr_wpen == (exp_go ? d[7] : wp0), {req, " protect enable"}, sr_wpen, exp_go ? d[7] : wp0);
    if (exp_go) m_bp = d[3:2];
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL R7 watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed, len;
    seed = $urandom(32'd7151);
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(wel == 0, "R1 wel", wel, 0);
    chk(sr_bp == 0 && sr_wpen == 0, "R1 status", {sr_wpen, sr_bp}, 0);

    // R2 latch control
    pulse_wel(1); chk(wel == 1, "R2 set", wel, 1);
    pulse_wel(0); chk(wel == 0, "R2 clear", wel, 0);

    // R6 chip erase without latch: nothing starts
    do_erase(2, 0, 0, "R6");
    // full chip erase establishes known contents
    pulse_wel(1);
    do_erase(2, 0, 1, "R8");
    check_region(0, MEM_B, "R9 chip erase contents");

    // R6 program ignored without latch
    do_program(256 + 10, 4, 1, 0, "R6");
    check_region(256, 256, "R6 array unchanged");

    // R3 wrap across page end, then re-program for AND behaviour
    pulse_wel(1); do_program(256 + 254, 3, 1, 1, "R3");
    check_region(256, 256, "R3 wrapped page");
    pulse_wel(1); do_program(256 + 254, 3, 1, 1, "R3");
    check_region(256, 256, "R3 clear-only reprogram");
    pulse_wel(1); do_program(256 + 77, 1, 1, 1, "R3");
    check_region(256, 256, "R3 single byte");

    // R4 more than a page of data (page 4, sector 2)
    pulse_wel(1); do_program(1024 + 10, 300, 1, 1, "R4");
    check_region(1024, 256, "R4 overwrite on wrap");

    // R5 unaligned frame end discards the command
    pulse_wel(1); do_program(1536 + 3, 5, 0, 0, "R5");
    chk(wel == 1, "R5 latch kept", wel, 1);
    check_region(1536, 256, "R5 array unchanged");

    // R9 sector erase selected by a middle address
    do_erase(1, 300, 1, "R9");
    check_region(0, MEM_B, "R9 sector erase");

    // R11 / R10 lock top half
    pulse_wel(1); do_status(8'h08, 1, "R11 set level 2");
    pulse_wel(1); do_program(1536 + 1, 2, 1, 0, "R10 locked program");
    chk(wel == 1, "R10 latch kept", wel, 1);
    do_erase(1, 1100, 0, "R10 locked sector erase");
    pulse_wel(1); do_program(20, 2, 1, 1, "R10 unlocked program");
    pulse_wel(1); do_erase(2, 0, 1, "R10 chip erase skips locked");
    check_region(0, MEM_B, "R10 contents after partial chip erase");
    pulse_wel(1); do_status(8'h00, 1, "R11 unlock");

    // R12 inputs ignored while busy
    pulse_wel(1);
    start_cmd(1, 600);
    end_frame(1);
    begin
      realtime t0;
      t0 = $realtime;
      repeat (10) @(negedge clk);
      pulse_wel(0);
      chk(wel == 1, "R12 clear ignored while busy", wel, 1);
      start_cmd(0, 700); send_byte(8'h00); end_frame(1);
      while (busy && ($realtime - t0) < 100000.0) @(negedge clk);
      len = int'(($realtime - t0) / 10.0);
      chk(len == T_SECT, "R12 cycle length undisturbed", len, T_SECT);
      for (int a = 512; a < 1024; a++) model[a] = 8'hFF;
    end
    pulse_wel(1);
    end_frame(1);
    busy_len(len);
    chk(len == 0, "R12 no command captured while busy", len, 0);
    check_region(512, 512, "R12 array after ignored program");

    // R11 hardware protection
    do_status(8'h80, 1, "R11 enable protect");
    prot_n = 0;
    pulse_wel(1); do_status(8'h00, 0, "R11 refused while pin low");
    prot_n = 1;
    do_status(8'h00, 1, "R11 accepted when pin high");

    // random programs and erases
    for (int it = 0; it < 16; it++) begin
      int a, n;
      a = int'($urandom % MEM_B);
      n = 1 + int'($urandom % 300);
      pulse_wel(1);
      if (it % 5 == 4) begin
        do_erase(1, a, 1, "R9 random");
        check_region(a & ~(SECT_B - 1), SECT_B, "R9 random sector");
      end else begin
        do_program(a, n, 1, 1, "R3 random");
        check_region(a & ~255, 256, "R3/R4 random page");
      end
    end

    // R13 read latency on a known byte
    pulse_wel(1); do_program(5, 1, 1, 1, "R13 setup");
    begin
      logic [7:0] d;
      read_byte(5, d);
      chk(d == model[5], "R13 read data", d, model[5]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule